// File: doc/BRIEF.md
# Reset Sequencer with Strap Capture

This block gathers every reason to reset a controller into one sequence. An active-low external reset line and two internal requests, one from a watchdog and one from software, all start the same sequence. During that sequence the block turns on the open-drain pull-down of the reset pad and holds the core in reset. It then releases the core one clock after the pull-down lets go.

On that release edge the block captures two configuration straps and holds them until the next reset. The first strap selects internal or external program memory. The second strap, when it reads low, puts every output of the device in high impedance so that the device is isolated on its board. The block also keeps a per-source record of what caused the last reset, which the host can clear. It returns the power mode to normal run on any reset and presents the fixed address of the first instruction fetch.

Timing is counted in system clocks. A state time is `STATE_CLKS` clocks, and the pull-down pulse lasts `PULSE_STATES` state times. The external line is brought into the clock domain by a `SYNC_STAGES`-flop synchronizer. Reset asserts the core asynchronously and releases it synchronously.

Top module: `rst_seq`

## Requirements
- R1: While `rst_pin_n` is low, `pin_pd` is 1 and `core_rst_n` is 0, with no clock edge needed, for as long as the line stays low.
- R2: After `rst_pin_n` returns high, `pin_pd` stays 1 for SYNC_STAGES + STATE_CLKS*PULSE_STATES clocks (2 + 32 = 34 with defaults), then drops.
- R3: A `wdt_req` or `sw_req` sampled high at a clock edge turns `pin_pd` on for STATE_CLKS*PULSE_STATES clocks (32) starting at that edge. A new request during the pulse restarts the full count from its own edge.
- R4: `pin_pd` high always implies `core_rst_n` low. `core_rst_n` rises exactly one clock after `pin_pd` falls.
- R5: `code_internal` takes the value of `code_strap` (1 = internal program memory) at the clock edge where `core_rst_n` rises. Later changes of `code_strap` have no effect until the next reset.
- R6: `iso_hiz` becomes 1 if `iso_strap_n` is 0 at the release edge, and stays 1 until the next reset. While `core_rst_n` is 0, both `iso_hiz` and `code_internal` read 0.
- R7: `fetch_addr` always reads `BOOT_ADDR`, which is 16'h2080 by default.
- R8: `rst_src` has one bit per source: bit 0 = external line, bit 1 = watchdog, bit 2 = software. A low external line forces it to 3'b001 at once. An internal request ORs in its bit at the sampling edge. `src_clr_we` clears the bits set in `src_clr_mask`. When a request and a clear of the same bit fall in the same cycle, the request wins.
- R9: `pwr_mode` is 2'b00 for run, 2'b01 for idle and 2'b10 for powerdown. `pm_we` loads it from `pm_val` only while `core_rst_n` is 1. Any reset forces it to 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_pin_n | input | 1 | Sensed level of the external reset line, active low |
| wdt_req | input | 1 | Watchdog reset request, synchronous |
| sw_req | input | 1 | Software reset request, synchronous |
| code_strap | input | 1 | Program memory strap, 1 = internal |
| iso_strap_n | input | 1 | Isolation strap, 0 = tristate all outputs |
| src_clr_we | input | 1 | Host clear strobe for the source record |
| src_clr_mask | input | 3 | Source bits to clear |
| pm_we | input | 1 | Power mode write strobe |
| pm_val | input | 2 | Power mode to write |
| pin_pd | output | 1 | Enable of the open-drain pull-down on the reset pad |
| core_rst_n | output | 1 | Reset to the core, active low |
| code_internal | output | 1 | Captured program memory select |
| iso_hiz | output | 1 | Captured isolation mode, 1 = all outputs tristated |
| rst_src | output | 3 | Record of the reset causes |
| pwr_mode | output | 2 | Current power mode |
| fetch_addr | output | 16 | Address of the first instruction fetch |

## Verification
The hardest case to reach from the ports is a second internal request that lands in the middle of an active pulse. Only a request sampled on the exact intended edge shows whether the counter restarts or extends. The stimulus drives the requests a fixed delay after the clock edge and counts edges between them, so the expected pulse of 42 clocks follows directly. The same timing puts a watchdog request and a host clear of all source bits in one cycle, to confirm that the request wins. A scoreboard measures the length of each pull-down pulse and the captured straps at every release.

// File: rtl/rsq_pkg.sv
package rsq_pkg;
   localparam int SRC_PIN  = 0;
   localparam int SRC_WDOG = 1;
   localparam int SRC_SOFT = 2;
   localparam int SRC_N    = 3;

   typedef enum logic [1:0] {
      PM_RUN  = 2'b00,
      PM_IDLE = 2'b01,
      PM_DOWN = 2'b10,
      PM_RSVD = 2'b11
   } pm_t;
endpackage

// File: rtl/rsq_sync.sv
module rsq_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic arst_n,
   output logic q
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("rsq_sync: STAGES must be 2 or more");
      end
   endgenerate

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) chain <= '0;
      else         chain <= {chain[STAGES-2:0], 1'b1};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/rsq_pulse.sv
module rsq_pulse #(
   parameter int CLKS = 32
) (
   input  logic clk,
   input  logic arst_n,
   input  logic run,
   input  logic trig,
   output logic active,
   output logic rdy,
   output logic rel
);
   localparam int            CW   = $clog2(CLKS + 1);
   localparam logic [CW-1:0] FULL = CW'(CLKS);

   logic [CW-1:0] cnt;
   logic          rdy_q;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         cnt   <= FULL;
         rdy_q <= 1'b0;
      end else if (trig) begin
         cnt   <= FULL;
         rdy_q <= 1'b0;
      end else begin
         if (!run)              cnt <= FULL;
         else if (cnt != '0)    cnt <= cnt - CW'(1);
         if (run && cnt == '0)  rdy_q <= 1'b1;
      end
   end

   assign active = (cnt != '0);
   assign rdy    = rdy_q;
   assign rel    = run && (cnt == '0) && !rdy_q && !trig;
endmodule

// File: rtl/rsq_straps.sv
module rsq_straps (
   input  logic clk,
   input  logic arst_n,
   input  logic clr,
   input  logic load,
   input  logic code_in,
   input  logic iso_n_in,
   output logic code_q,
   output logic iso_q
);
   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         code_q <= 1'b0;
         iso_q  <= 1'b0;
      end else if (clr) begin
         code_q <= 1'b0;
         iso_q  <= 1'b0;
      end else if (load) begin
         code_q <= code_in;
         iso_q  <= !iso_n_in;
      end
   end
endmodule

// File: rtl/rsq_src.sv
module rsq_src import rsq_pkg::*; (
   input  logic             clk,
   input  logic             arst_n,
   input  logic [SRC_N-1:0] set_vec,
   input  logic             clr_we,
   input  logic [SRC_N-1:0] clr_mask,
   output logic [SRC_N-1:0] src
);
   logic [SRC_N-1:0] keep;

   assign keep = clr_we ? ~clr_mask : '1;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         src          <= '0;
         src[SRC_PIN] <= 1'b1;
      end else begin
         src <= (src & keep) | set_vec;
      end
   end
endmodule

// File: rtl/rst_seq.sv
module rst_seq import rsq_pkg::*; #(
   parameter int          STATE_CLKS   = 2,
   parameter int          PULSE_STATES = 16,
   parameter int          SYNC_STAGES  = 2,
   parameter logic [15:0] BOOT_ADDR    = 16'h2080
) (
   input  logic        clk,
   input  logic        rst_pin_n,
   input  logic        wdt_req,
   input  logic        sw_req,
   input  logic        code_strap,
   input  logic        iso_strap_n,
   input  logic        src_clr_we,
   input  logic [2:0]  src_clr_mask,
   input  logic        pm_we,
   input  logic [1:0]  pm_val,
   output logic        pin_pd,
   output logic        core_rst_n,
   output logic        code_internal,
   output logic        iso_hiz,
   output logic [2:0]  rst_src,
   output logic [1:0]  pwr_mode,
   output logic [15:0] fetch_addr
);
   localparam int PULSE_CLKS = STATE_CLKS * PULSE_STATES;

   logic             pin_sync;
   logic             trig;
   logic             rel;
   logic             pulse_on;
   logic             run_ok;
   logic [SRC_N-1:0] set_vec;
   pm_t              pm_q;

   generate
      if (STATE_CLKS < 1 || PULSE_STATES < 1) begin : g_bad_pulse
         $error("rst_seq: pulse length parameters must be positive");
      end
      if (SRC_N != 3) begin : g_bad_src
         $error("rst_seq: source record width must match the port");
      end
   endgenerate

   assign trig = wdt_req | sw_req;

   always_comb begin
      set_vec           = '0;
      set_vec[SRC_WDOG] = wdt_req;
      set_vec[SRC_SOFT] = sw_req;
   end

   rsq_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .arst_n (rst_pin_n),
      .q      (pin_sync)
   );

   rsq_pulse #(.CLKS(PULSE_CLKS)) u_pulse (
      .clk    (clk),
      .arst_n (rst_pin_n),
      .run    (pin_sync),
      .trig   (trig),
      .active (pulse_on),
      .rdy    (run_ok),
      .rel    (rel)
   );

   rsq_straps u_straps (
      .clk      (clk),
      .arst_n   (rst_pin_n),
      .clr      (trig),
      .load     (rel),
      .code_in  (code_strap),
      .iso_n_in (iso_strap_n),
      .code_q   (code_internal),
      .iso_q    (iso_hiz)
   );

   rsq_src u_src (
      .clk      (clk),
      .arst_n   (rst_pin_n),
      .set_vec  (set_vec),
      .clr_we   (src_clr_we),
      .clr_mask (src_clr_mask),
      .src      (rst_src)
   );

   always_ff @(posedge clk or negedge rst_pin_n) begin
      if (!rst_pin_n)           pm_q <= PM_RUN;
      else if (trig)            pm_q <= PM_RUN;
      else if (pm_we && run_ok) pm_q <= pm_t'(pm_val);
   end

   assign pin_pd     = pulse_on;
   assign core_rst_n = run_ok;
   assign pwr_mode   = pm_q;
   assign fetch_addr = BOOT_ADDR;
endmodule

// File: rtl/rsq_chk.sv
module rsq_chk (
   input logic       clk,
   input logic       rst_pin_n,
   input logic       wdt_req,
   input logic       sw_req,
   input logic       pin_pd,
   input logic       core_rst_n,
   input logic       code_internal,
   input logic       iso_hiz,
   input logic [1:0] pwr_mode
);
   always @(negedge clk) begin
      if (!rst_pin_n) begin
         AST_PIN_HOLDS_RESET: assert (pin_pd && !core_rst_n); // R1
      end
   end

   AST_REQ_STARTS_PULSE: assert property (@(posedge clk) disable iff (!rst_pin_n)
      (wdt_req || sw_req) |=> (pin_pd && !core_rst_n)); // R3

   AST_PD_IMPLIES_RESET: assert property (@(posedge clk) disable iff (!rst_pin_n)
      pin_pd |-> !core_rst_n); // R4

   AST_RELEASE_AFTER_PD: assert property (@(posedge clk) disable iff (!rst_pin_n)
      $rose(core_rst_n) |-> $past(!pin_pd)); // R4

   AST_STRAPS_FROZEN: assert property (@(posedge clk) disable iff (!rst_pin_n)
      (core_rst_n && $past(core_rst_n)) |-> ($stable(code_internal) && $stable(iso_hiz))); // R5

   AST_STRAPS_CLEAR_IN_RESET: assert property (@(posedge clk) disable iff (!rst_pin_n)
      !core_rst_n |-> (!code_internal && !iso_hiz)); // R6

   AST_PM_RUN_IN_RESET: assert property (@(posedge clk) disable iff (!rst_pin_n)
      !core_rst_n |-> (pwr_mode == 2'b00)); // R9
endmodule

bind rst_seq rsq_chk u_chk (
   .clk           (clk),
   .rst_pin_n     (rst_pin_n),
   .wdt_req       (wdt_req),
   .sw_req        (sw_req),
   .pin_pd        (pin_pd),
   .core_rst_n    (core_rst_n),
   .code_internal (code_internal),
   .iso_hiz       (iso_hiz),
   .pwr_mode      (pwr_mode)
);

// File: tb/sim_rst_seq.sv
module sim_rst_seq;
   logic        clk = 1'b0;
   logic        rst_pin_n, wdt_req, sw_req, code_strap, iso_strap_n;
   logic        src_clr_we, pm_we;
   logic [2:0]  src_clr_mask;
   logic [1:0]  pm_val;
   logic        pin_pd, core_rst_n, code_internal, iso_hiz;
   logic [2:0]  rst_src;
   logic [1:0]  pwr_mode;
   logic [15:0] fetch_addr;

   always #4 clk = ~clk;

   rst_seq u0 (
      .clk(clk), .rst_pin_n(rst_pin_n), .wdt_req(wdt_req), .sw_req(sw_req),
      .code_strap(code_strap), .iso_strap_n(iso_strap_n),
      .src_clr_we(src_clr_we), .src_clr_mask(src_clr_mask),
      .pm_we(pm_we), .pm_val(pm_val),
      .pin_pd(pin_pd), .core_rst_n(core_rst_n), .code_internal(code_internal),
      .iso_hiz(iso_hiz), .rst_src(rst_src), .pwr_mode(pwr_mode), .fetch_addr(fetch_addr)
   );

   typedef struct {
      string      tag;
      int         len;
      logic       code;
      logic       iso;
      logic [2:0] src;
   } exp_t;

   exp_t sbq[$];
   int   n_cmp = 0;
   int   n_bad = 0;
   bit   done  = 0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic finish_up;
      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   task automatic push(input string tag, input int len, input logic code,
                       input logic iso, input logic [2:0] src);
      exp_t e;
      e.tag = tag; e.len = len; e.code = code; e.iso = iso; e.src = src;
      sbq.push_back(e);
   endtask

   task automatic pulse_req(input bit wdt, input bit sw);
      @(posedge clk); #2;
      wdt_req = wdt; sw_req = sw;
      @(posedge clk); #2;
      wdt_req = 0; sw_req = 0;
   endtask

   task automatic wait_core;
      int n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!core_rst_n && n < 500);
      repeat (3) @(negedge clk);
   endtask

   // Monitor: measures each pull-down pulse after the external line is high
   initial begin : mon
      int   run_len;
      exp_t e;
      run_len = 0;
      forever begin
         @(negedge clk);
         if (!rst_pin_n) run_len = 0;
         else if (pin_pd) run_len++;
         else if (run_len > 0) begin
            chk("R4 core held one clock after pull-down", {31'd0, core_rst_n}, 32'd0);
            @(negedge clk);
            chk("R4 core released", {31'd0, core_rst_n}, 32'd1);
            if (sbq.size() == 0) chk("R2 unexpected pulse", 32'd1, 32'd0);
            else begin
               e = sbq.pop_front();
               chk({e.tag, " pulse length"}, run_len, e.len);
               chk("R5 captured code strap", {31'd0, code_internal}, {31'd0, e.code});
               chk("R6 captured isolation", {31'd0, iso_hiz}, {31'd0, e.iso});
               chk("R8 reset source", {29'd0, rst_src}, {29'd0, e.src});
            end
            run_len = 0;
         end
      end
   end

   initial begin : wdog
      repeat (20000) @(posedge clk);
      chk("watchdog expired", 32'd1, 32'd0);
      finish_up();
   end

   initial begin : drv
      rst_pin_n = 0; wdt_req = 0; sw_req = 0; code_strap = 1; iso_strap_n = 1;
      src_clr_we = 0; src_clr_mask = 3'b000; pm_we = 0; pm_val = 2'b00;

      repeat (3) @(negedge clk);
      chk("R1 pull-down while line low", {31'd0, pin_pd}, 32'd1);
      chk("R1 core held while line low", {31'd0, core_rst_n}, 32'd0);
      chk("R6 straps zero in reset", {30'd0, code_internal, iso_hiz}, 32'd0);
      chk("R8 source after line reset", {29'd0, rst_src}, 32'd1);
      chk("R9 run mode in reset", {30'd0, pwr_mode}, 32'd0);
      chk("R7 boot address", {16'd0, fetch_addr}, 32'h2080);

      // line release: 2 sync clocks + 32 pulse clocks
      push("R2", 34, 1'b1, 1'b0, 3'b001);
      @(posedge clk); #2; rst_pin_n = 1;
      wait_core();

      // straps changed after release have no effect
      code_strap = 0; iso_strap_n = 0;
      repeat (5) @(negedge clk);
      chk("R5 code strap ignored after release", {31'd0, code_internal}, 32'd1);
      chk("R6 isolation strap ignored after release", {31'd0, iso_hiz}, 32'd0);
      chk("R7 boot address after release", {16'd0, fetch_addr}, 32'h2080);
      iso_strap_n = 1;

      // power mode write while running
      @(posedge clk); #2; pm_we = 1; pm_val = 2'b01;
      @(posedge clk); #2; pm_we = 0;
      @(negedge clk);
      chk("R9 idle written", {30'd0, pwr_mode}, 32'd1);

      // host clears the line bit
      @(posedge clk); #2; src_clr_we = 1; src_clr_mask = 3'b001;
      @(posedge clk); #2; src_clr_we = 0;
      @(negedge clk);
      chk("R8 host clear", {29'd0, rst_src}, 32'd0);

      // watchdog reset; power mode returns to run, writes ignored in reset
      push("R3 watchdog", 32, 1'b0, 1'b0, 3'b010);
      pulse_req(1, 0);
      @(negedge clk);
      chk("R9 reset returns to run", {30'd0, pwr_mode}, 32'd0);
      @(posedge clk); #2; pm_we = 1; pm_val = 2'b10;
      @(posedge clk); #2; pm_we = 0;
      @(negedge clk);
      chk("R9 write ignored in reset", {30'd0, pwr_mode}, 32'd0);
      wait_core();

      // software reset retriggered by watchdog ten clocks later: 10 + 32
      code_strap = 1;
      push("R3 retrigger", 42, 1'b1, 1'b0, 3'b110);
      @(posedge clk); #2; sw_req = 1;
      @(posedge clk); #2; sw_req = 0;
      repeat (9) @(posedge clk);
      #2; wdt_req = 1;
      @(posedge clk); #2; wdt_req = 0;
      wait_core();

      // line reset held long, isolation strap low at release
      iso_strap_n = 0;
      @(posedge clk); #2; rst_pin_n = 0;
      repeat (20) @(negedge clk);
      chk("R1 pull-down held during long low", {31'd0, pin_pd}, 32'd1);
      chk("R1 core held during long low", {31'd0, core_rst_n}, 32'd0);
      chk("R8 line reset overrides record", {29'd0, rst_src}, 32'd1);
      push("R6 isolation", 34, 1'b1, 1'b1, 3'b001);
      @(posedge clk); #2; rst_pin_n = 1;
      wait_core();
      iso_strap_n = 1;
      repeat (4) @(negedge clk);
      chk("R6 isolation kept until next reset", {31'd0, iso_hiz}, 32'd1);

      // software reset leaves isolation mode
      push("R6 exit isolation", 32, 1'b1, 1'b0, 3'b101);
      pulse_req(0, 1);
      wait_core();

      // watchdog request and full clear in the same cycle: request wins
      push("R8 set over clear", 32, 1'b1, 1'b0, 3'b010);
      @(posedge clk); #2; wdt_req = 1; src_clr_we = 1; src_clr_mask = 3'b111;
      @(posedge clk); #2; wdt_req = 0; src_clr_we = 0;
      wait_core();

      repeat (5) @(negedge clk);
      chk("R2 all pulses observed", sbq.size(), 32'd0);
      finish_up();
   end
endmodule